// File: doc/BRIEF.md
# Privileged Interrupt Arbiter

This block decides, on request, whether a hart should take an interrupt and which one. Each cycle it sees the hart's current privilege level, the machine and supervisor global interrupt enables, a vector of pending interrupt lines, a mask saying which of those lines are handed down to supervisor mode, and a flag that is high while the hart sits in debug mode.

Pending lines that are not handed down form the machine group. The machine group is qualified by a privilege-dependent enable. The handed-down lines are looked at only when nothing in the machine group qualifies, and they are qualified by the supervisor enable. From whichever group survives, the lowest-numbered line wins.

When evaluation is requested and a winner exists, the block raises a one-cycle strobe. With the strobe it presents a cause word that has the interrupt flag in its top bit and the winning line number in its low bits. The trap-entry logic upstream consumes these two outputs.

Top module: `irq_arbiter`

## Requirements
- R1: Machine-group lines are eligible when `cur_priv` is below machine (user = 2'd0, supervisor = 2'd1), or when `cur_priv` is machine (2'd3) and `m_gie` is 1.
- R2: The machine group is the set of lines with `irq_pend` = 1 and `irq_deleg` = 0. It is empty whenever the machine enable of R1 is false.
- R3: Delegated lines (`irq_pend` = 1 and `irq_deleg` = 1) compete only when the qualified machine group is empty. Any qualified machine line therefore wins over a lower-numbered delegated line.
- R4: Delegated lines are eligible when `cur_priv` is user, or when `cur_priv` is supervisor and `s_gie` is 1. They are never eligible at machine privilege.
- R5: While `in_debug` is 1 at an evaluation, no interrupt is taken.
- R6: The winner is the least significant set bit of the surviving candidate set.
- R7: A taken interrupt's cause word has bit XLEN-1 set to 1. Bits IDXW-1:0 hold the winner's line number, and all other bits are 0.
- R8: `take_irq` is high for exactly the one cycle after a cycle with `eval_req` = 1 and a non-empty candidate set. A cycle without `eval_req` never produces a strobe.
- R9: `irq_cause` changes only on a cycle where `take_irq` is high. Otherwise it holds its last value.
- R10: After reset, `take_irq` is 0 and `irq_cause` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_req | input | 1 | Request an arbitration this cycle |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| irq_pend | input | NIRQ | Pending interrupt lines |
| irq_deleg | input | NIRQ | 1 = line handed down to supervisor |
| in_debug | input | 1 | Hart is in debug mode |
| take_irq | output | 1 | One-cycle strobe: take an interrupt |
| irq_cause | output | XLEN | Interrupt flag at the top bit, line number in the low bits |

## Verification
The two selections that can collide in one evaluation are the machine-group pick and the delegated pick. The bench provokes this by placing a delegated line below a non-delegated one at user and supervisor privilege, and judges that the higher, non-delegated line wins. A second collision is a debug-mode request that arrives together with live candidates; there the strobe must stay low and the cause must keep its old value. Random patterns at every legal privilege level, with sparse and dense pending vectors, are compared against a priority-encoder model in the bench.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int XLEN = 32,
  parameter int NIRQ = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eval_req,
  input  logic [1:0]      cur_priv,
  input  logic            m_gie,
  input  logic            s_gie,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NIRQ-1:0] irq_deleg,
  input  logic            in_debug,
  output logic            take_irq,
  output logic [XLEN-1:0] irq_cause
);
  localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  logic            m_on, s_on, fire;
  logic [NIRQ-1:0] m_set, s_set, cand;
  logic [IDXW-1:0] win;

  assign m_on  = (cur_priv < PRIV_M) || ((cur_priv == PRIV_M) && m_gie);
  assign s_on  = (cur_priv < PRIV_S) || ((cur_priv == PRIV_S) && s_gie);
  assign m_set = irq_pend & ~irq_deleg & {NIRQ{m_on}};
  assign s_set = irq_pend & irq_deleg & {NIRQ{s_on}};
  assign cand  = (|m_set) ? m_set : s_set;
  assign fire  = eval_req && !in_debug && (|cand);

  always_comb begin
    win = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (cand[i]) win = IDXW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_irq  <= 1'b0;
      irq_cause <= '0;
    end else begin
      take_irq <= fire;
      if (fire) irq_cause <= {1'b1, {(XLEN-1-IDXW){1'b0}}, win};
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int XLEN = 32,
  parameter int NIRQ = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            eval_req,
  input logic [1:0]      cur_priv,
  input logic [NIRQ-1:0] irq_pend,
  input logic [NIRQ-1:0] irq_deleg,
  input logic            in_debug,
  input logic            take_irq,
  input logic [XLEN-1:0] irq_cause
);
  localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  AST_NO_EVAL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_req |=> !take_irq);                                           // R8
  AST_DEBUG_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    in_debug |=> !take_irq);                                            // R5
  AST_EMPTY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend == '0) |=> !take_irq);                                    // R8
  AST_CAUSE_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (irq_cause[XLEN-1] && irq_cause[XLEN-2:IDXW] == '0));  // R7
  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> ((($past(irq_pend) >> irq_cause[IDXW-1:0]) & NIRQ'(1)) != '0)); // R6
  AST_MACHINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && $past(cur_priv) == 2'd0 && $past(irq_pend & ~irq_deleg) != '0)
      |-> ((($past(irq_deleg) >> irq_cause[IDXW-1:0]) & NIRQ'(1)) == '0)); // R3
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_irq |-> $stable(irq_cause));                                  // R9
endmodule

bind irq_arbiter irq_arbiter_chk #(.XLEN(XLEN), .NIRQ(NIRQ)) chk_i (
  .clk(clk), .rst_n(rst_n), .eval_req(eval_req), .cur_priv(cur_priv),
  .irq_pend(irq_pend), .irq_deleg(irq_deleg), .in_debug(in_debug),
  .take_irq(take_irq), .irq_cause(irq_cause)
);

// File: tb/irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_arbiter_tb_top;
  localparam int XLEN = 32;
  localparam int NIRQ = 16;

  logic clk = 0, rst_n = 0, eval_req = 0, m_gie = 0, s_gie = 0, in_debug = 0;
  logic [1:0] cur_priv = 2'd3;
  logic [NIRQ-1:0] irq_pend = '0, irq_deleg = '0;
  logic take_irq;
  logic [XLEN-1:0] irq_cause;
  int errors = 0, checks = 0;
  logic [XLEN-1:0] last_cause = '0;

  always #5 clk = ~clk;

  irq_arbiter #(.XLEN(XLEN), .NIRQ(NIRQ)) dut_i (.*);

  function automatic logic [5:0] model(input logic [1:0] p, input logic mg, input logic sg,
                                       input logic [NIRQ-1:0] pd, input logic [NIRQ-1:0] dl,
                                       input logic dbg);
    logic me, se;
    logic [NIRQ-1:0] c;
    me = (p != 2'd3) || mg;
    se = (p == 2'd0) || (p == 2'd1 && sg);
    c = pd & ~dl & {NIRQ{me}};
    if (c == '0) c = pd & dl & {NIRQ{se}};
    if (dbg || c == '0) return 6'd0;
    for (int i = 0; i < NIRQ; i++) if (c[i]) return {1'b1, 5'(i)};
    return 6'd0;
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic arb(input string req, input logic [1:0] p, input logic mg, input logic sg,
                     input logic [NIRQ-1:0] pd, input logic [NIRQ-1:0] dl, input logic dbg);
    logic [5:0] e;
    logic [XLEN-1:0] ec;
    e = model(p, mg, sg, pd, dl, dbg);
    @(negedge clk);
    cur_priv = p; m_gie = mg; s_gie = sg; irq_pend = pd; irq_deleg = dl; in_debug = dbg;
    eval_req = 1;
    @(negedge clk);
    eval_req = 0;
    ec = e[5] ? {1'b1, {(XLEN-5){1'b0}}, e[3:0]} : last_cause;
    check({req, " strobe"}, XLEN'(take_irq), XLEN'(e[5]));
    check({req, " cause"}, irq_cause, ec);
    last_cause = ec;
    @(negedge clk);
    check("R8 single-cycle strobe", XLEN'(take_irq), '0);
    check("R9 cause held", irq_cause, ec);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset strobe", XLEN'(take_irq), '0);
    check("R10 reset cause", irq_cause, '0);
    rst_n = 1;
    // R3: non-delegated line 9 beats delegated line 2 at user privilege
    arb("R3 machine first", 2'd0, 0, 1, 16'h0204, 16'h0004, 0);
    // R4: delegated only at supervisor with s_gie off -> none
    arb("R4 sup disabled", 2'd1, 1, 0, 16'h0010, 16'h0010, 0);
    arb("R4 sup enabled", 2'd1, 0, 1, 16'h0030, 16'h0030, 0);
    // R4: delegated never at machine
    arb("R4 machine blocks deleg", 2'd3, 1, 1, 16'h00F0, 16'h00F0, 0);
    // R1: machine with m_gie off / on
    arb("R1 mgie off", 2'd3, 0, 1, 16'h0080, 16'h0000, 0);
    arb("R1 mgie on", 2'd3, 1, 0, 16'h8080, 16'h0000, 0);
    // R1/R2: supervisor ignores m_gie for machine group
    arb("R2 below machine", 2'd1, 0, 0, 16'h0400, 16'h0100, 0);
    // R5: debug with live candidates
    arb("R5 debug", 2'd0, 1, 1, 16'hFFFF, 16'h0000, 1);
    // R6/R7: top line and bit 0
    arb("R6 top line", 2'd0, 0, 0, 16'h8000, 16'h0000, 0);
    arb("R7 line zero", 2'd0, 0, 0, 16'hFFFF, 16'h0000, 0);
    // R8: no pending
    arb("R8 empty", 2'd0, 1, 1, 16'h0000, 16'hFFFF, 0);
    // R8: inputs live but no eval
    @(negedge clk);
    irq_pend = 16'hFFFF; irq_deleg = '0; cur_priv = 2'd0; in_debug = 0;
    @(negedge clk);
    check("R8 no eval", XLEN'(take_irq), '0);
    check("R9 no eval cause", irq_cause, last_cause);
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      logic [1:0] p;
      logic [NIRQ-1:0] pd;
      case ($urandom % 3) 0: p = 2'd0; 1: p = 2'd1; default: p = 2'd3; endcase
      pd = NIRQ'($urandom);
      if (n % 2 == 0) pd = pd & NIRQ'($urandom) & NIRQ'($urandom);
      arb("R6 random", p, 1'($urandom), 1'($urandom), pd, NIRQ'($urandom),
          ($urandom % 8) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule